// File: doc/BRIEF.md
# Prototype-Window I/O Port Pair

This block is a small peripheral for an 8-bit, ISA-style expansion bus. It holds one output port and one input port that live in the I/O range reserved for prototype cards (300h to 31Fh). All ten address lines take part in the decode, and every access must also have the address-enable line low, which means the processor owns the bus. Because of this, neither port answers at any address except its own.

The active-low read and write strobes are first brought into the block clock domain by two-flop synchronizers. A three-state cycle controller then follows each bus access. The states are `ST_IDLE`, `ST_WRITE` and `ST_READ`. The transitions are:
- IDLE to WRITE when a synchronized write strobe arrives and the address matches the output port.
- IDLE to READ when a synchronized read strobe arrives and the address matches the input port.
- WRITE to IDLE when the write strobe goes away. At that moment the data bus is captured into the output latch if the address still matches.
- READ to IDLE when the read strobe goes away.

When both strobes arrive together, the write is taken first. While a matching read is in progress, the input pins drive the data bus through an output enable, which stands in for a three-state buffer.

Top module: `isa_proto_io`

## Requirements
- R1: While reset is asserted, and right after it, `out_pins` reads 00h, `bus_data_oe` is 0 and `bus_data_out` is 00h.
- R2: A write to address 31Fh with `bus_aen`=0 keeps the old `out_pins` value while `bus_iow_n` is low. The new `bus_data_in` byte appears on `out_pins` no later than 4 clock edges after `bus_iow_n` returns high.
- R3: A write cycle with `bus_aen`=1 leaves `out_pins` unchanged, even at address 31Fh.
- R4: A write to any 10-bit address other than 31Fh leaves `out_pins` unchanged. This includes 11Fh, 21Fh and 01Fh, which differ from 31Fh only in the upper lines, and the input port address 31Eh.
- R5: A read at 31Eh with `bus_aen`=0 and `bus_ior_n` low raises `bus_data_oe` within 4 clock edges. While it is raised, `bus_data_out` equals `in_pins` in the same cycle, and it follows any change on them.
- R6: `bus_data_oe` stays 0 for reads with `bus_aen`=1, for reads at any other address (31Fh and 11Eh included), and whenever no read is active. While `bus_data_oe` is 0, `bus_data_out` is 00h.
- R7: `bus_data_oe` returns to 0 no later than 3 clock edges after `bus_ior_n` returns high.
- R8: `out_pins` holds its value across reads and across cycles that are not decoded, until the next matching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | I/O address lines |
| bus_aen | input | 1 | Address enable; 0 while the processor owns the bus |
| bus_ior_n | input | 1 | Active-low I/O read strobe |
| bus_iow_n | input | 1 | Active-low I/O write strobe |
| bus_data_in | input | 8 | Data bus as seen by the block |
| bus_data_out | output | 8 | Data driven toward the bus during a matching read |
| bus_data_oe | output | 1 | Enable for the bus data driver |
| in_pins | input | 8 | External input port pins |
| out_pins | output | 8 | Latched output port pins |

## Verification
Suppose the controller lands in the wrong state. It might stay stuck in READ, or move to WRITE on an address that does not match. At the ports, this shows up as `bus_data_oe` staying high more than three edges after the read strobe has gone, or as `out_pins` taking a byte from a cycle that was not decoded. In both cases the fault is visible on the first access that follows. A decoder that ignored one address line would show up the first time an alias such as 11Fh or 21Fh is written. The bench sends these aliases back to back with real writes and checks `out_pins` after every one of them.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int SYNC_DEP = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int    WIDTH  = 2,
    parameter int    STAGES = 2,
    parameter logic  IDLE_V = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{IDLE_V}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[LAST];
    end
endmodule

// File: rtl/io_addr_match.sv
module io_addr_match #(
    parameter int          AW        = 10,
    parameter logic [9:0]  PORT_ADDR = 10'h31F,
    parameter logic [9:0]  WIN_LO    = 10'h300,
    parameter logic [9:0]  WIN_HI    = 10'h31F
) (
    input  logic [AW-1:0] addr,
    input  logic          aen,
    output logic          hit
);
    localparam logic [AW-1:0] PORT_A = AW'(PORT_ADDR);
    localparam bit IN_WINDOW = (PORT_ADDR >= WIN_LO) && (PORT_ADDR <= WIN_HI);

    always_comb begin
        hit = IN_WINDOW && !aen && (addr == PORT_A);
    end
endmodule

// File: rtl/io_cycle_fsm.sv
module io_cycle_fsm
    import isa_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic rd_hit,
    input  logic wr_hit,
    output logic capture,
    output logic drive_en
);
    cyc_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_req && wr_hit)      nxt = ST_WRITE;
                else if (rd_req && rd_hit) nxt = ST_READ;
            end
            ST_WRITE: if (!wr_req) nxt = ST_IDLE;
            ST_READ:  if (!rd_req) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        capture  = 1'b0;
        drive_en = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: capture  = !wr_req && wr_hit;
            ST_READ:  drive_en = rd_hit;
            default:  ;
        endcase
    end
endmodule

// File: rtl/isa_proto_io.sv
module isa_proto_io
    import isa_io_pkg::*;
#(
    parameter int         AW       = ADDR_W,
    parameter int         DW       = DATA_W,
    parameter logic [9:0] OUT_ADDR = 10'h31F,
    parameter logic [9:0] IN_ADDR  = 10'h31E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_aen,
    input  logic          bus_ior_n,
    input  logic          bus_iow_n,
    input  logic [DW-1:0] bus_data_in,
    output logic [DW-1:0] bus_data_out,
    output logic          bus_data_oe,
    input  logic [DW-1:0] in_pins,
    output logic [DW-1:0] out_pins
);
    logic [1:0]    strb_n_s;
    logic          rd_req, wr_req, rd_hit, wr_hit, capture, drive_en;
    logic [DW-1:0] out_q;

    strobe_sync #(.WIDTH(2), .STAGES(SYNC_DEP), .IDLE_V(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_iow_n, bus_ior_n}), .q(strb_n_s)
    );
    assign rd_req = !strb_n_s[0];
    assign wr_req = !strb_n_s[1];

    io_addr_match #(.AW(AW), .PORT_ADDR(OUT_ADDR)) u_wr_dec (
        .addr(bus_addr), .aen(bus_aen), .hit(wr_hit)
    );
    io_addr_match #(.AW(AW), .PORT_ADDR(IN_ADDR)) u_rd_dec (
        .addr(bus_addr), .aen(bus_aen), .hit(rd_hit)
    );

    io_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .wr_req(wr_req),
        .rd_hit(rd_hit), .wr_hit(wr_hit),
        .capture(capture), .drive_en(drive_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_q <= '0;
        else if (capture) out_q <= bus_data_in;
    end

    assign out_pins     = out_q;
    assign bus_data_oe  = drive_en;
    assign bus_data_out = drive_en ? in_pins : '0;
endmodule

// File: rtl/isa_proto_io_chk.sv
module isa_proto_io_chk #(
    parameter int         AW       = 10,
    parameter int         DW       = 8,
    parameter logic [9:0] OUT_ADDR = 10'h31F,
    parameter logic [9:0] IN_ADDR  = 10'h31E
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_aen,
    input logic [DW-1:0] bus_data_out,
    input logic          bus_data_oe,
    input logic [DW-1:0] in_pins,
    input logic [DW-1:0] out_pins
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (out_pins == '0 && !bus_data_oe));

    // R6
    oe_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (!bus_aen && bus_addr == AW'(IN_ADDR)));

    // R6
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_data_oe |-> (bus_data_out == '0));

    // R5
    drive_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (bus_data_out == in_pins));

    // R4
    out_from_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && out_pins != $past(out_pins))
            |-> $past(!bus_aen && bus_addr == AW'(OUT_ADDR)));
endmodule

bind isa_proto_io isa_proto_io_chk #(
    .AW(AW), .DW(DW), .OUT_ADDR(OUT_ADDR), .IN_ADDR(IN_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .in_pins(in_pins), .out_pins(out_pins)
);

// File: tb/isa_proto_io_tb.sv
module isa_proto_io_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_aen = 1'b1;
    logic       bus_ior_n = 1'b1;
    logic       bus_iow_n = 1'b1;
    logic [7:0] bus_data_in = '0;
    logic [7:0] bus_data_out;
    logic       bus_data_oe;
    logic [7:0] in_pins = '0;
    logic [7:0] out_pins;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    isa_proto_io u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
        .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
        .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .in_pins(in_pins), .out_pins(out_pins)
    );

    // fields: addr(10) aen(1) is_read(1) data(8) exp_out(8) exp_oe(1) exp_data(8)
    localparam int VW = 37;
    localparam int NV = 12;
    localparam logic [VW-1:0] VEC [NV] = '{
        {10'h31F, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 8'h00},  // R2
        {10'h31F, 1'b1, 1'b0, 8'h3C, 8'hA5, 1'b0, 8'h00},  // R3
        {10'h11F, 1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0, 8'h00},  // R4
        {10'h21F, 1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0, 8'h00},  // R4
        {10'h31E, 1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0, 8'h00},  // R4
        {10'h31F, 1'b0, 1'b0, 8'h5A, 8'h5A, 1'b0, 8'h00},  // R2
        {10'h31E, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b1, 8'hC3},  // R5
        {10'h31E, 1'b1, 1'b1, 8'hC3, 8'h5A, 1'b0, 8'h00},  // R6
        {10'h11E, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b0, 8'h00},  // R6
        {10'h31F, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b0, 8'h00},  // R6
        {10'h31E, 1'b0, 1'b1, 8'h7E, 8'h5A, 1'b1, 8'h7E},  // R5 R8
        {10'h01F, 1'b0, 1'b0, 8'hFF, 8'h5A, 1'b0, 8'h00}   // R4
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        check8("R1 out in reset", out_pins, 8'h00);
        check8("R1 oe in reset", {7'b0, bus_data_oe}, 8'h00);
        check8("R1 data in reset", bus_data_out, 8'h00);
        rst_n = 1'b1;
        wait_n(2);
        check8("R1 out after reset", out_pins, 8'h00);

        for (int i = 0; i < NV; i++) begin
            automatic logic [VW-1:0] v = VEC[i];
            bus_addr = v[36:27];
            bus_aen  = v[26];
            if (v[25]) begin
                in_pins = v[24:17];
                bus_ior_n = 1'b0;
                wait_n(5);
                check8($sformatf("vec%0d R5/R6 oe", i), {7'b0, bus_data_oe}, {7'b0, v[8]});
                check8($sformatf("vec%0d R5/R6 data", i), bus_data_out, v[7:0]);
                bus_ior_n = 1'b1;
                wait_n(5);
            end else begin
                bus_data_in = v[24:17];
                bus_iow_n = 1'b0;
                wait_n(5);
                bus_iow_n = 1'b1;
                wait_n(5);
            end
            check8($sformatf("vec%0d R2/R3/R4/R8 out", i), out_pins, v[16:9]);
            bus_aen = 1'b1;
            wait_n(1);
        end

        // R2: hold during strobe, update within 4 edges after release
        bus_addr = 10'h31F; bus_aen = 1'b0; bus_data_in = 8'h99;
        bus_iow_n = 1'b0;
        wait_n(6);
        check8("R2 hold while strobe low", out_pins, 8'h5A);
        bus_iow_n = 1'b1;
        wait_n(4);
        check8("R2 update after strobe", out_pins, 8'h99);
        bus_aen = 1'b1;
        wait_n(2);

        // R5 pins tracked during read, R7 release timing
        bus_addr = 10'h31E; bus_aen = 1'b0; in_pins = 8'h11;
        bus_ior_n = 1'b0;
        wait_n(4);
        check8("R5 oe within 4", {7'b0, bus_data_oe}, 8'h01);
        in_pins = 8'h22;
        wait_n(1);
        check8("R5 tracks pins", bus_data_out, 8'h22);
        bus_ior_n = 1'b1;
        wait_n(3);
        check8("R7 oe released", {7'b0, bus_data_oe}, 8'h00);
        check8("R6 data zero when idle", bus_data_out, 8'h00);
        check8("R8 out held after read", out_pins, 8'h99);

        // R4/R6: both strobes at output port address: latched, no drive
        bus_addr = 10'h31F; bus_data_in = 8'h44;
        bus_iow_n = 1'b0; bus_ior_n = 1'b0;
        wait_n(5);
        check8("R6 no oe at write port", {7'b0, bus_data_oe}, 8'h00);
        bus_iow_n = 1'b1; bus_ior_n = 1'b1;
        wait_n(5);
        check8("R2 latch with both strobes", out_pins, 8'h44);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule